// File: doc/BRIEF.md
# MDIO PHY Discovery and Link Monitor

This block is the management-side master for a two-wire PHY management bus. After system reset it pulses the PHY's active-low hardware reset and then waits for the PHY to settle. It then walks every 5-bit PHY address from the lowest to the highest, reading both identifier registers at each one, and locks onto the first address whose upper identifier word is neither all ones nor all zeros. From then on it reads the basic status register in a loop. Whenever the link bit is set, it also reads the vendor special status register and turns its three-bit speed/duplex field into flags.

The management clock comes from a parameterised divider of the system clock, so it can be held under 2.5 MHz. The data line is open-drain. The block only pulls it low or releases it, through separate in, out and output-enable pins. A single-entry host port lets other logic read or write any register of the found PHY. A host request waits in a holding slot and is carried out at the next gap between polling frames. If no address answers, the block raises a no-PHY flag and leaves the bus idle until a restart pulse.

Top module: `mdio_phy_monitor`

## Requirements
- R1: After reset, `phy_rst_n` is low for exactly RST_LOW_CYC cycles, then high for at least RST_WAIT_CYC cycles. During both periods `mdc` stays low and `mdio_oe` stays low.
- R2: While a frame runs, `mdc` is high for MDC_HALF system cycles and low for MDC_HALF system cycles in each bit. It is held low between frames.
- R3: Each frame is 32 released (one) bits, then start 01, opcode (10 = read, 01 = write), the 5-bit PHY address and the 5-bit register number, each MSB first. These are followed by two turnaround bits and 16 data bits, MSB first. `mdio_oe` changes only on a falling `mdc` edge. Read data is sampled when `mdc` rises. During a read, both turnaround bits and all data bits are released.
- R4: `mdio_o` is always 0. A one is sent by releasing the line (`mdio_oe` = 0).
- R5: The scan reads register 2 and then register 3 at addresses 0, 1, 2 and upward. An address whose register-2 value is 16'hFFFF or 16'h0000 is skipped. At the first other address, `phy_found` goes to 1, `phy_addr` takes that address, and `phy_id` takes {reg2, reg3}.
- R6: If address 31 is skipped, `no_phy` goes to 1, `phy_found` stays 0 and no further frames run.
- R7: `restart` restarts the whole sequence from R1 only while `no_phy` is 1. It is ignored otherwise.
- R8: After discovery, register 1 is read repeatedly. When its bit 2 reads 0, `link_up`, `speed_100`, `full_duplex` and `mode_invalid` are all 0.
- R9: When register-1 bit 2 reads 1, register 31 is read and `link_up` is set. Its bits [4:2] decode as follows: 001 gives 10 Mb/s half, 101 gives 10 Mb/s full, 010 gives 100 Mb/s half, 110 gives 100 Mb/s full. `speed_100` is set for 100 Mb/s and `full_duplex` for full duplex. Any other code sets `mode_invalid` and clears both flags.
- R10: `host_req` is accepted while `host_busy` is 0. The access runs on the found PHY only between polling frames. A one-cycle `host_done` follows, and for reads `host_rdata` holds the data. Polling then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Rerun the sequence after a failed scan |
| phy_rst_n | output | 1 | Active-low PHY hardware reset |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Management data output value, constant 0 |
| mdio_oe | output | 1 | Pull the data line low when 1 |
| host_req | input | 1 | Host access request (one cycle) |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 5 | Register number for the host access |
| host_wdata | input | 16 | Write data |
| host_busy | output | 1 | A host access is pending or running |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Data of the last host read |
| phy_found | output | 1 | A PHY was located |
| phy_addr | output | 5 | Address of the located PHY |
| phy_id | output | 32 | {register 2, register 3} of the located PHY |
| no_phy | output | 1 | Scan ended without a responder |
| link_up | output | 1 | Link reported up |
| speed_100 | output | 1 | Link runs at 100 Mb/s |
| full_duplex | output | 1 | Link runs full duplex |
| mode_invalid | output | 1 | Speed/duplex field held an unknown code |

## Verification
The assertions on bit timing and line release assume a few things about the inputs. MDC_HALF is at least 2. The external PHY changes the data line only after a falling `mdc` edge and leaves it stable until the next rising edge. `host_req` is raised only while `host_busy` is low. The bench's PHY model drives the line only from its falling-edge process. Its host driver task waits for `host_busy` to clear before each request. Stimulus that changes the model's link and mode settings is applied between frames, because the model latches its reply at the end of the header.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

    localparam logic [4:0] REG_STATUS = 5'h01;
    localparam logic [4:0] REG_ID_HI  = 5'h02;
    localparam logic [4:0] REG_ID_LO  = 5'h03;
    localparam logic [4:0] REG_VENDOR = 5'h1F;
    localparam logic [4:0] LAST_ADDR  = 5'd31;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_ID1,
        ST_ID2,
        ST_LINK,
        ST_MODE,
        ST_HOST,
        ST_NOPHY
    } seq_state_t;

    typedef struct packed {
        logic ok;
        logic fast;
        logic full;
    } link_mode_t;

    // speed/duplex code in bits [4:2] of the vendor status register
    function automatic link_mode_t decode_mode(input logic [2:0] code);
        link_mode_t m;
        unique case (code)
            3'b001:  m = '{ok: 1'b1, fast: 1'b0, full: 1'b0};
            3'b101:  m = '{ok: 1'b1, fast: 1'b0, full: 1'b1};
            3'b010:  m = '{ok: 1'b1, fast: 1'b1, full: 1'b0};
            3'b110:  m = '{ok: 1'b1, fast: 1'b1, full: 1'b1};
            default: m = '{ok: 1'b0, fast: 1'b0, full: 1'b0};
        endcase
        return m;
    endfunction

    function automatic logic id_empty(input logic [15:0] v);
        return (v == 16'hFFFF) || (v == 16'h0000);
    endfunction

    // the 32 bits that follow the preamble; a 1 means "release the line"
    function automatic logic [31:0] build_hdr(input logic rd, input logic [4:0] pa,
                                              input logic [4:0] ra, input logic [15:0] wd);
        return {2'b01, rd ? OP_RD : OP_WR, pa, ra,
                rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign rise = run && (cnt == LAST) && !mdc;
    assign fall = run && (cnt == LAST) && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_HIGH_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |=> mdc); // R2
    AST_MDC_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |=> !mdc); // R2

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mon_pkg::*;
#(
    parameter int MDC_HALF = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd,
    input  logic [4:0]  pa,
    input  logic [4:0]  ra,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_oe
);
    localparam logic [5:0] LAST_BIT   = 6'd63;
    localparam logic [5:0] FIRST_DATA = 6'd48;
    localparam logic [5:0] FIRST_TA   = 6'd46;

    logic [5:0]  idx;
    logic [31:0] hdr;
    logic        rd_q;
    logic        rise, fall;
    logic        bitv;

    mdio_clk_div #(.HALF(MDC_HALF)) u_div (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .mdc (mdc),
        .rise(rise),
        .fall(fall)
    );

    assign bitv    = idx[5] ? hdr[5'(LAST_BIT - idx)] : 1'b1;
    assign mdio_oe = busy && !bitv;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            hdr   <= '0;
            rd_q  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                idx   <= '0;
                hdr   <= build_hdr(rd, pa, ra, wdata);
                rd_q  <= rd;
                rdata <= '0;
            end else if (busy) begin
                if (rise && rd_q && idx >= FIRST_DATA)
                    rdata <= {rdata[14:0], mdio_i};
                if (fall) begin
                    if (idx == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> $fell(mdc)); // R3
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_q && idx >= FIRST_TA) |-> !mdio_oe); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R2

endmodule

// File: rtl/mdio_phy_monitor.sv
module mdio_phy_monitor
    import mdio_mon_pkg::*;
#(
    parameter int MDC_HALF     = 40,
    parameter int RST_LOW_CYC  = 2_000_000,
    parameter int RST_WAIT_CYC = 10_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    output logic        phy_rst_n,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [4:0]  host_reg,
    input  logic [15:0] host_wdata,
    output logic        host_busy,
    output logic        host_done,
    output logic [15:0] host_rdata,
    output logic        phy_found,
    output logic [4:0]  phy_addr,
    output logic [31:0] phy_id,
    output logic        no_phy,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        mode_invalid
);
    localparam int TMAX = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LOW_LAST  = TW'(RST_LOW_CYC - 1);
    localparam logic [TW-1:0] WAIT_LAST = TW'(RST_WAIT_CYC - 1);

    seq_state_t  state;
    logic [TW-1:0] tmr;
    logic        fw;
    logic [4:0]  scan_addr;
    logic [15:0] id_hi;
    logic        host_pend, hq_wr;
    logic [4:0]  hq_reg;
    logic [15:0] hq_wd;

    logic        eng_start, eng_rd, eng_busy, eng_done;
    logic [4:0]  eng_pa, eng_ra;
    logic [15:0] eng_wd, eng_rdata;
    link_mode_t  mode_dec;

    assign mdio_o    = 1'b0;
    assign phy_rst_n = (state != ST_RST_LOW);
    assign host_busy = host_pend;
    assign mode_dec  = decode_mode(eng_rdata[4:2]);

    always_comb begin
        eng_rd = 1'b1;
        eng_pa = phy_addr;
        eng_ra = REG_STATUS;
        eng_wd = '0;
        eng_start = 1'b0;
        unique case (state)
            ST_ID1: begin
                eng_pa = scan_addr; eng_ra = REG_ID_HI; eng_start = !fw;
            end
            ST_ID2: begin
                eng_pa = scan_addr; eng_ra = REG_ID_LO; eng_start = !fw;
            end
            ST_LINK: eng_start = !fw && !host_pend;
            ST_MODE: begin
                eng_ra = REG_VENDOR; eng_start = !fw;
            end
            ST_HOST: begin
                eng_rd = !hq_wr; eng_ra = hq_reg; eng_wd = hq_wd; eng_start = !fw;
            end
            default: eng_start = 1'b0;
        endcase
    end

    mdio_frame_engine #(.MDC_HALF(MDC_HALF)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .rd     (eng_rd),
        .pa     (eng_pa),
        .ra     (eng_ra),
        .wdata  (eng_wd),
        .mdio_i (mdio_i),
        .busy   (eng_busy),
        .done   (eng_done),
        .rdata  (eng_rdata),
        .mdc    (mdc),
        .mdio_oe(mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RST_LOW;
            tmr          <= '0;
            fw           <= 1'b0;
            scan_addr    <= '0;
            id_hi        <= '0;
            host_pend    <= 1'b0;
            hq_wr        <= 1'b0;
            hq_reg       <= '0;
            hq_wd        <= '0;
            host_done    <= 1'b0;
            host_rdata   <= '0;
            phy_found    <= 1'b0;
            phy_addr     <= '0;
            phy_id       <= '0;
            no_phy       <= 1'b0;
            link_up      <= 1'b0;
            speed_100    <= 1'b0;
            full_duplex  <= 1'b0;
            mode_invalid <= 1'b0;
        end else begin
            host_done <= 1'b0;
            if (host_req && !host_pend) begin
                host_pend <= 1'b1;
                hq_wr     <= host_wr;
                hq_reg    <= host_reg;
                hq_wd     <= host_wdata;
            end
            if (eng_start) fw <= 1'b1;
            if (eng_done)  fw <= 1'b0;

            unique case (state)
                ST_RST_LOW: begin
                    if (tmr == LOW_LAST) begin
                        tmr   <= '0;
                        state <= ST_RST_WAIT;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RST_WAIT: begin
                    if (tmr == WAIT_LAST) begin
                        tmr       <= '0;
                        scan_addr <= '0;
                        state     <= ST_ID1;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_ID1: if (eng_done) begin
                    id_hi <= eng_rdata;
                    state <= ST_ID2;
                end
                ST_ID2: if (eng_done) begin
                    if (!id_empty(id_hi)) begin
                        phy_found <= 1'b1;
                        phy_addr  <= scan_addr;
                        phy_id    <= {id_hi, eng_rdata};
                        state     <= ST_LINK;
                    end else if (scan_addr == LAST_ADDR) begin
                        no_phy <= 1'b1;
                        state  <= ST_NOPHY;
                    end else begin
                        scan_addr <= scan_addr + 1'b1;
                        state     <= ST_ID1;
                    end
                end
                ST_LINK: begin
                    if (!fw && host_pend) begin
                        state <= ST_HOST;
                    end else if (eng_done) begin
                        if (eng_rdata[2]) begin
                            state <= ST_MODE;
                        end else begin
                            link_up      <= 1'b0;
                            speed_100    <= 1'b0;
                            full_duplex  <= 1'b0;
                            mode_invalid <= 1'b0;
                        end
                    end
                end
                ST_MODE: if (eng_done) begin
                    link_up      <= 1'b1;
                    speed_100    <= mode_dec.fast;
                    full_duplex  <= mode_dec.full;
                    mode_invalid <= !mode_dec.ok;
                    state        <= ST_LINK;
                end
                ST_HOST: if (eng_done) begin
                    host_pend  <= 1'b0;
                    host_done  <= 1'b1;
                    host_rdata <= eng_rdata;
                    state      <= ST_LINK;
                end
                ST_NOPHY: if (restart) begin
                    no_phy    <= 1'b0;
                    phy_found <= 1'b0;
                    phy_addr  <= '0;
                    phy_id    <= '0;
                    tmr       <= '0;
                    state     <= ST_RST_LOW;
                end
                default: state <= ST_RST_LOW;
            endcase
        end
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RST_LOW || state == ST_RST_WAIT) |-> (!mdc && !mdio_oe)); // R1
    AST_NO_FRAME_CUT: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_busy); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (phy_found && $past(phy_found)) |-> $stable(phy_addr)); // R5
    AST_NOPHY_IDLE: assert property (@(posedge clk) disable iff (rst)
        no_phy |-> (!eng_busy && !phy_found)); // R6
    AST_FLAGS_NEED_LINK: assert property (@(posedge clk) disable iff (rst)
        !link_up |-> !(speed_100 || full_duplex || mode_invalid)); // R8
    AST_OUT_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> !mdio_o); // R4

endmodule

// File: tb/sim_mdio_phy_monitor.sv
`timescale 1ns/1ps
module sim_mdio_phy_monitor;
    localparam int HALF  = 2;
    localparam int RLOW  = 20;
    localparam int RWAIT = 30;

    logic clk = 1'b0, rst = 1'b1, restart = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [4:0] host_reg = '0;
    logic [15:0] host_wdata = '0;
    logic phy_rst_n, mdc, mdio_o, mdio_oe, host_busy, host_done;
    logic [15:0] host_rdata;
    logic phy_found, no_phy, link_up, speed_100, full_duplex, mode_invalid;
    logic [4:0] phy_addr;
    logic [31:0] phy_id;
    logic mdio_line, phy_en = 1'b0, phy_bit = 1'b1;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? 1'b0 : (phy_en ? phy_bit : 1'b1);

    mdio_phy_monitor #(.MDC_HALF(HALF), .RST_LOW_CYC(RLOW), .RST_WAIT_CYC(RWAIT)) u0 (
        .clk(clk), .rst(rst), .restart(restart), .phy_rst_n(phy_rst_n), .mdc(mdc),
        .mdio_i(mdio_line), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .host_req(host_req), .host_wr(host_wr), .host_reg(host_reg), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
        .phy_found(phy_found), .phy_addr(phy_addr), .phy_id(phy_id), .no_phy(no_phy),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .mode_invalid(mode_invalid)
    );

    // ---------------- PHY model ----------------
    bit present = 1;
    bit link = 0;
    logic [2:0] mode = 3'b000;
    logic [15:0] scratch = 16'h0000;
    int ones = 0, k = -1;
    logic [13:0] hb = '0;
    logic resp = 1'b0;
    logic [15:0] rv = '0, wv = '0;
    logic [1:0] mop = '0;
    logic [4:0] mpa = '0, mra = '0;

    function automatic logic responds(input logic [4:0] pa);
        return present && (pa == 5'd3 || pa == 5'd5 || pa == 5'd9);
    endfunction

    function automatic logic [15:0] reg_val(input logic [4:0] pa, input logic [4:0] ra);
        if (pa == 5'd3) return 16'h0000;
        if (pa == 5'd9) return (ra == 5'd2) ? 16'h2222 : 16'h0000;
        case (ra)
            5'd1:    return link ? 16'h782D : 16'h7809;
            5'd2:    return 16'h0A5C;
            5'd3:    return 16'hC3B1;
            5'd4:    return scratch;
            5'h1F:   return {11'd0, mode, 2'b00};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge rst) begin
        k = -1; ones = 0; resp = 1'b0; phy_en = 1'b0;
    end

    always @(posedge mdc) begin
        if (k < 0) begin
            if (mdio_line) ones++;
            else begin
                if (ones >= 32) k = 1;
                ones = 0;
            end
        end else begin
            if (k <= 13) hb[13-k] = mdio_line;
            if (k == 13) begin
                mop  = hb[11:10];
                mpa  = hb[9:5];
                mra  = hb[4:0];
                resp = (mop == 2'b10) && responds(mpa);
                rv   = reg_val(mpa, mra);
            end
            if (k >= 16) wv = {wv[14:0], mdio_line};
            if (k == 31 && mop == 2'b01 && mpa == 5'd5 && mra == 5'd4 && present)
                scratch = wv;
            k = (k == 31) ? -1 : k + 1;
            if (k < 0) ones = 0;
        end
    end

    always @(negedge mdc) begin
        if (resp && k == 15) begin
            phy_en = 1'b1; phy_bit = 1'b0;
        end else if (resp && k >= 16 && k <= 31) begin
            phy_en = 1'b1; phy_bit = rv[31-k];
        end else begin
            phy_en = 1'b0;
            if (k < 0) resp = 1'b0;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // R4: the output value pin is watched all run
    int drove_high = 0;
    always @(negedge clk) if (!rst && mdio_o !== 1'b0) drove_high++;

    // ---------------- scoreboard ----------------
    typedef struct packed { logic rd; logic [15:0] v; } exp_t;
    exp_t exp_q[$];

    task automatic host_op(input logic wr, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] ev);
        @(negedge clk);
        while (host_busy) @(negedge clk);
        host_wr = wr; host_reg = ra; host_wdata = wd; host_req = 1'b1;
        exp_q.push_back('{rd: !wr, v: ev});
        @(negedge clk);
        host_req = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && host_done) begin
            if (exp_q.size() == 0) chk("R10", "unexpected host_done", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.rd) chk("R10", "host read data", {16'd0, host_rdata}, {16'd0, e.v});
                else chk("R10", "write done while busy", {31'd0, host_busy}, 32'd0);
            end
        end
    end

    task automatic wait_flag(input int which, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (which == 0 && phy_found) return;
            if (which == 1 && no_phy) return;
            if (which == 2 && exp_q.size() == 0 && !host_busy) return;
        end
    endtask

    task automatic check_mode(input logic [2:0] m, input logic [3:0] exp);
        mode = m;
        repeat (2000) @(negedge clk);
        chk("R9", $sformatf("mode code %b {link,100,full,inv}", m),
            {28'd0, link_up, speed_100, full_duplex, mode_invalid}, {28'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        int n, m;
        bit seen_ignore;
        repeat (5) @(negedge clk);
        chk("R1", "reset state {rst_n,mdc,oe,found,nophy,link}",
            {26'd0, phy_rst_n, mdc, mdio_oe, phy_found, no_phy, link_up}, 32'd0);

        // R1: reset pulse length, then quiet settle time
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!phy_rst_n && n < 1000) begin n++; @(negedge clk); end
        chk("R1", "phy_rst_n low cycles", n, RLOW);
        m = 0;
        while (!mdc && !mdio_oe && m < 1000) begin m++; @(negedge clk); end
        chk("R1", "settle before first MDC edge at least RWAIT", {31'd0, m >= RWAIT}, 32'd1);

        // R5: scan skips 3 (zero id), finds 5 before 9
        wait_flag(0, 20000);
        chk("R5", "phy_found", {31'd0, phy_found}, 32'd1);
        chk("R5", "phy_addr", {27'd0, phy_addr}, 32'd5);
        chk("R3", "phy_id bits MSB first", phy_id, 32'h0A5CC3B1);
        chk("R6", "no_phy stays low", {31'd0, no_phy}, 32'd0);

        // R2: MDC high time
        while (mdc) @(negedge clk);
        while (!mdc) @(negedge clk);
        n = 0;
        while (mdc) begin n++; @(negedge clk); end
        chk("R2", "mdc high cycles", n, HALF);

        // R8: link down
        repeat (1500) @(negedge clk);
        chk("R8", "link down flags", {28'd0, link_up, speed_100, full_duplex, mode_invalid}, 32'd0);

        // R7: restart ignored while a PHY is tracked
        restart = 1'b1; @(negedge clk); restart = 1'b0;
        seen_ignore = 1;
        for (int i = 0; i < 50; i++) begin
            if (!phy_rst_n || !phy_found) seen_ignore = 0;
            @(negedge clk);
        end
        chk("R7", "restart ignored during polling", {31'd0, seen_ignore}, 32'd1);

        // R9: decode all four valid codes and an unknown one
        link = 1;
        check_mode(3'b110, 4'b1110);
        check_mode(3'b001, 4'b1000);
        check_mode(3'b101, 4'b1010);
        check_mode(3'b010, 4'b1100);
        check_mode(3'b011, 4'b1001);

        link = 0;
        repeat (2000) @(negedge clk);
        chk("R8", "link dropped flags", {28'd0, link_up, speed_100, full_duplex, mode_invalid}, 32'd0);

        // R10: host accesses through the scoreboard
        link = 1; mode = 3'b110;
        host_op(1'b1, 5'd4, 16'hBEEF, 16'h0000);
        host_op(1'b0, 5'd4, 16'h0000, 16'hBEEF);
        host_op(1'b0, 5'd2, 16'h0000, 16'h0A5C);
        host_op(1'b0, 5'd3, 16'h0000, 16'hC3B1);
        wait_flag(2, 10000);
        chk("R10", "all host accesses completed", exp_q.size(), 32'd0);
        repeat (2000) @(negedge clk);
        chk("R10", "polling resumed after host", {31'd0, link_up && speed_100 && full_duplex}, 32'd1);

        // R6: no PHY anywhere
        @(negedge clk); rst = 1'b1; present = 0; link = 0;
        repeat (4) @(negedge clk); rst = 1'b0;
        wait_flag(1, 40000);
        chk("R6", "no_phy after full scan", {31'd0, no_phy}, 32'd1);
        chk("R6", "phy_found stays low", {31'd0, phy_found}, 32'd0);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            if (mdc || mdio_oe) n++;
            @(negedge clk);
        end
        chk("R6", "bus idle after failed scan", n, 32'd0);

        // R7: restart from the no-PHY state reruns the sequence
        present = 1;
        restart = 1'b1; @(negedge clk); restart = 1'b0;
        chk("R7", "phy_rst_n pulled low on restart", {31'd0, phy_rst_n}, 32'd0);
        wait_flag(0, 20000);
        chk("R7", "found after restart {found,nophy,addr}",
            {25'd0, phy_found, no_phy, phy_addr}, {25'd0, 1'b1, 1'b0, 5'd5});

        chk("R4", "cycles with mdio_o high", drove_high, 32'd0);
        report();
    end
endmodule